// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns one 21-bit pixel word into four serial lanes on every pixel clock. The word holds 18 colour bits (six each of red, green and blue) and three timing bits (line sync, frame sync, data enable). Three lanes carry seven data bits each. The fourth lane carries a forwarded clock pattern, so a receiver can find the frame boundary and recover the pixel clock. The bit clock `clk_bit` comes from an external PLL and runs at seven times the pixel rate, phase-locked to it. The block provides the seven slots of each period.

A strap input selects the pixel clock edge that captures the word. An active-low power-down pin resets the whole block, tri-states the lanes and drops the enable sent to the bit-clock source. A monitor in the bit-clock domain watches a toggle flag from the pixel domain. If the pixel clock disappears, all lanes are pulled low. When the clock returns, serialization restarts on its own.

A three-state machine runs in the bit-clock domain:
- HUNT is the state after reset. The lanes are held low.
- HUNT goes to RUN on the first synchronized pixel edge.
- RUN goes to LOST when the miss counter saturates.
- LOST goes back to RUN on the next synchronized pixel edge.

Top module: `sl7_link_tx`

## Requirements
- R1: With `strobe_rise` at 1 the input word is sampled on the rising edge of `clk_pix`. With `strobe_rise` at 0 it is sampled on the falling edge.
- R2: The word is numbered red[5:0] as bits 0–5, green[5:0] as bits 6–11, blue[5:0] as bits 12–17, line sync as bit 18, frame sync as bit 19 and data enable as bit 20. Lane L (0..2) carries bits 7L..7L+6, and its slot s (0..6) carries bit 7L+6−s, so the highest bit goes first.
- R3: In the RUN state the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every frame, which gives four high slots and three low slots in a row.
- R4: Each lane sends one seven-slot frame per pixel period, one slot per `clk_bit` period. The frame that starts in pixel period k+1 carries the word captured at the selected edge of period k.
- R5: While `pd_n` is 0, all four lanes are high impedance and `bitclk_en` is 0. All stored words are cleared, so the first frame after release carries an all-zero word.
- R6: With `pd_n` at 1 and no pixel clock edge seen yet, all four lanes are driven to 0 (not high impedance) and `bitclk_en` is 1.
- R7: After 32 consecutive `clk_bit` periods with no synchronized pixel edge, all four lanes are driven to 0. Loss is never declared while edges arrive every seven bit periods.
- R8: When the pixel clock restarts after a loss, frames resume without `pd_n` being cycled, and their content follows R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| clk_bit | input | 1 | Bit clock, seven times the pixel rate, phase-locked |
| pd_n | input | 1 | Active-low power-down; asynchronous reset of the whole block |
| strobe_rise | input | 1 | Capture edge select: 1 rising, 0 falling |
| red | input | 6 | Red colour bits |
| grn | input | 6 | Green colour bits |
| blu | input | 6 | Blue colour bits |
| line_sync | input | 1 | Horizontal timing bit |
| frame_sync | input | 1 | Vertical timing bit |
| data_en | input | 1 | Active-video qualifier |
| tx_dat | output | 3 | Serial data lanes, high impedance in power-down |
| tx_clk | output | 1 | Forwarded clock lane, high impedance in power-down |
| bitclk_en | output | 1 | Enable for the external bit-clock source |

## Verification
All four lanes are deserialized by locking onto the clock-lane pattern. Each recovered word is compared with an arithmetic model of the capture edge and the one-period latency.

The sweep uses several word patterns:
- A walking one, which exposes any lane or slot swap because the single set bit lands in the wrong place.
- A walking zero, which exposes bits stuck high.
- All-zero and all-one words.
- Arithmetic mixed words.

Input words change between the rising and the falling pixel edge, so a wrong strobe choice yields a word one period off. The same sweep runs in both strobe settings, around a power-down in mid-run and around a stopped pixel clock. The stopped-clock runs show both the stale frames that continue before the loss limit and the low lanes after it.

// File: rtl/sl7_pkg.sv
package sl7_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOST = 2'd2
    } link_state_e;

endpackage

// File: rtl/sl7_capture.sv
// Pixel-domain front end: captures on both edges, keeps the one selected by
// the strap, and restages it on the rising edge so both settings give the
// bit domain a word that is stable for a whole period. Also toggles a flag
// every rising edge for the clock monitor.
module sl7_capture #(
    parameter int WORD_W = 21
) (
    input  logic              clk_pix,
    input  logic              rst_n,
    input  logic              rise_sel,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] hold_o,
    output logic              tog_o
);

    logic [WORD_W-1:0] cap_r;
    logic [WORD_W-1:0] cap_f;

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) cap_r <= '0;
        else        cap_r <= word_i;
    end

    always_ff @(negedge clk_pix or negedge rst_n) begin
        if (!rst_n) cap_f <= '0;
        else        cap_f <= word_i;
    end

    always_ff @(posedge clk_pix or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= '0;
            tog_o  <= 1'b0;
        end else begin
            hold_o <= rise_sel ? cap_r : cap_f;
            tog_o  <= ~tog_o;
        end
    end

endmodule

// File: rtl/sl7_sync.sv
module sl7_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] ff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];

endmodule

// File: rtl/sl7_clkmon.sv
// Bit-domain watchdog on the synchronized pixel toggle flag.
module sl7_clkmon #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_s,
    output logic edge_o,
    output logic lost_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic             tog_d;
    logic [CNT_W-1:0] miss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_d <= 1'b0;
        else        tog_d <= tog_s;
    end

    assign edge_o = tog_s ^ tog_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                miss_q <= '0;
        else if (edge_o)           miss_q <= '0;
        else if (miss_q != CNT_MAX) miss_q <= miss_q + 1'b1;
    end

    assign lost_o = (miss_q == CNT_MAX);

endmodule

// File: rtl/sl7_shifter.sv
module sl7_shifter #(
    parameter int SLOTS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SLOTS-1:0] par_i,
    output logic             bit_o
);

    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sh_q <= '0;
        else if (load) sh_q <= par_i;
        else           sh_q <= {sh_q[SLOTS-2:0], 1'b0};
    end

    assign bit_o = sh_q[SLOTS-1];

endmodule

// File: rtl/sl7_link_tx.sv
module sl7_link_tx
    import sl7_pkg::*;
#(
    parameter int               COLOR_W     = 6,
    parameter int               SLOTS       = 7,
    parameter int               LANES       = (3 * COLOR_W + 3) / SLOTS,
    parameter int               SYNC_STAGES = 2,
    parameter int               LOSS_LIMIT  = 32,
    parameter logic [SLOTS-1:0] CLK_PAT     = 7'b1100011
) (
    input  logic               clk_pix,
    input  logic               clk_bit,
    input  logic               pd_n,
    input  logic               strobe_rise,
    input  logic [COLOR_W-1:0] red,
    input  logic [COLOR_W-1:0] grn,
    input  logic [COLOR_W-1:0] blu,
    input  logic               line_sync,
    input  logic               frame_sync,
    input  logic               data_en,
    output logic [LANES-1:0]   tx_dat,
    output logic               tx_clk,
    output logic               bitclk_en
);

    localparam int WORD_W = LANES * SLOTS;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [WORD_W-1:0] word_in;
    logic [WORD_W-1:0] word_hold;
    logic              tog_pix;
    logic              tog_s;
    logic              edge_w;
    logic              lost_w;
    logic              load_w;
    logic [SLOT_W-1:0] slot_q;
    logic [LANES-1:0]  sh_dat;
    logic              sh_clk;
    logic [LANES-1:0]  dat_val;
    logic              clk_val;
    link_state_e       state_q;
    link_state_e       state_d;

    assign word_in = WORD_W'({data_en, frame_sync, line_sync, blu, grn, red});

    sl7_capture #(.WORD_W(WORD_W)) u_cap (
        .clk_pix  (clk_pix),
        .rst_n    (pd_n),
        .rise_sel (strobe_rise),
        .word_i   (word_in),
        .hold_o   (word_hold),
        .tog_o    (tog_pix)
    );

    sl7_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_bit),
        .rst_n (pd_n),
        .d     (tog_pix),
        .q     (tog_s)
    );

    sl7_clkmon #(.LIMIT(LOSS_LIMIT)) u_mon (
        .clk    (clk_bit),
        .rst_n  (pd_n),
        .tog_s  (tog_s),
        .edge_o (edge_w),
        .lost_o (lost_w)
    );

    // state register
    always_ff @(posedge clk_bit or negedge pd_n) begin
        if (!pd_n) state_q <= ST_HUNT;
        else       state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (edge_w) state_d = ST_RUN;
            ST_RUN:  if (lost_w) state_d = ST_LOST;
            ST_LOST: if (edge_w) state_d = ST_RUN;
            default: state_d = ST_HUNT;
        endcase
    end

    assign load_w = (state_d == ST_RUN) &&
                    (edge_w || (state_q == ST_RUN && slot_q == SLOT_LAST));

    always_ff @(posedge clk_bit or negedge pd_n) begin
        if (!pd_n)
            slot_q <= '0;
        else if (edge_w || load_w || slot_q == SLOT_LAST)
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sl7_shifter #(.SLOTS(SLOTS)) u_sh (
            .clk   (clk_bit),
            .rst_n (pd_n),
            .load  (load_w),
            .par_i (word_hold[l*SLOTS +: SLOTS]),
            .bit_o (sh_dat[l])
        );
    end

    sl7_shifter #(.SLOTS(SLOTS)) u_sh_clk (
        .clk   (clk_bit),
        .rst_n (pd_n),
        .load  (load_w),
        .par_i (CLK_PAT),
        .bit_o (sh_clk)
    );

    // outputs
    always_comb begin
        dat_val = '0;
        clk_val = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                dat_val = sh_dat;
                clk_val = sh_clk;
            end
            ST_HUNT, ST_LOST: begin
                dat_val = '0;
                clk_val = 1'b0;
            end
            default: begin
                dat_val = '0;
                clk_val = 1'b0;
            end
        endcase
    end

    assign tx_dat    = pd_n ? dat_val : {LANES{1'bz}};
    assign tx_clk    = pd_n ? clk_val : 1'bz;
    assign bitclk_en = pd_n;

endmodule

// File: rtl/sl7_link_tx_chk.sv
module sl7_link_tx_chk
    import sl7_pkg::*;
#(
    parameter int               SLOTS   = 7,
    parameter int               LANES   = 3,
    parameter int               SLOT_W  = 3,
    parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
    input logic              clk_bit,
    input logic              pd_n,
    input logic              bitclk_en,
    input link_state_e       state_q,
    input logic [SLOT_W-1:0] slot_q,
    input logic              edge_w,
    input logic              lost_w,
    input logic [LANES-1:0]  dat_val,
    input logic              clk_val
);

    p_pd_quiet_r5: assert property (@(posedge clk_bit)
        !pd_n |-> (!bitclk_en && dat_val == '0 && !clk_val));

    p_lost_low_r7: assert property (@(posedge clk_bit) disable iff (!pd_n)
        (lost_w && !edge_w) |=> (dat_val == '0 && !clk_val));

    p_clk_pattern_r3: assert property (@(posedge clk_bit) disable iff (!pd_n)
        (state_q == ST_RUN) |-> (clk_val == CLK_PAT[(SLOTS - 1) - int'(slot_q)]));

    p_slot_bound_r4: assert property (@(posedge clk_bit) disable iff (!pd_n)
        int'(slot_q) < SLOTS);

    p_realign_r4: assert property (@(posedge clk_bit) disable iff (!pd_n)
        edge_w |=> (slot_q == '0));

    p_resume_r8: assert property (@(posedge clk_bit) disable iff (!pd_n)
        (state_q == ST_LOST && edge_w) |=> (state_q == ST_RUN));

endmodule

bind sl7_link_tx sl7_link_tx_chk #(
    .SLOTS   (SLOTS),
    .LANES   (LANES),
    .SLOT_W  (SLOT_W),
    .CLK_PAT (CLK_PAT)
) u_chk (
    .clk_bit   (clk_bit),
    .pd_n      (pd_n),
    .bitclk_en (bitclk_en),
    .state_q   (state_q),
    .slot_q    (slot_q),
    .edge_w    (edge_w),
    .lost_w    (lost_w),
    .dat_val   (dat_val),
    .clk_val   (clk_val)
);

// File: tb/sim_sl7_link_tx.sv
module sim_sl7_link_tx;

    localparam int W  = 21;
    localparam int SL = 7;
    localparam int NL = 3;
    localparam int NP = 64;

    logic clk_bit     = 1'b1;
    logic clk_pix     = 1'b0;
    logic pd_n        = 1'b0;
    logic strobe_rise = 1'b1;
    logic [W-1:0] w_in = '0;
    logic [5:0] red, grn, blu;
    logic line_sync, frame_sync, data_en;
    wire  [NL-1:0] tx_dat;
    wire  tx_clk;
    wire  bitclk_en;

    assign {data_en, frame_sync, line_sync, blu, grn, red} = w_in;

    sl7_link_tx u0 (
        .clk_pix     (clk_pix),
        .clk_bit     (clk_bit),
        .pd_n        (pd_n),
        .strobe_rise (strobe_rise),
        .red         (red),
        .grn         (grn),
        .blu         (blu),
        .line_sync   (line_sync),
        .frame_sync  (frame_sync),
        .data_en     (data_en),
        .tx_dat      (tx_dat),
        .tx_clk      (tx_clk),
        .bitclk_en   (bitclk_en)
    );

    always #4 clk_bit = ~clk_bit;

    int n_vec = 0;
    int n_bad = 0;
    int frames = 0;
    bit chk_en = 0;
    bit done = 0;
    logic pd_req = 1'b0;
    logic str_req = 1'b1;
    logic [W-1:0] cap_m = '0;
    logic [W-1:0] exp_stage = '0;
    logic [SL-1:0] h_clk = '0;
    logic [SL-1:0] h_dat [NL];
    logic [W-1:0]  h_exp [SL];
    logic [W-1:0]  rec;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int i);
        logic [W-1:0] one = W'(1);
        if (i < W)          return one << i;
        else if (i < 2 * W) return ~(one << (i - W));
        else if (i == 2 * W) return '0;
        else if (i == 2 * W + 1) return '1;
        else return W'((i * 32'h0001_A2B3) ^ 32'h0015_5A5A);
    endfunction

    // One pixel period; called at 2 ns past a period boundary.
    // Rising pixel edge at +0, inputs change at +12, falling edge at +24.
    task automatic pix_period(input bit run, input logic [W-1:0] w);
        if (run) begin
            exp_stage = cap_m;
            clk_pix = 1'b1;
            if (pd_n && strobe_rise) cap_m = w_in;
        end
        #12;
        w_in = w;
        pd_n = pd_req;
        strobe_rise = str_req;
        if (!pd_n) cap_m = '0;
        #12;
        if (run) begin
            clk_pix = 1'b0;
            if (pd_n && !strobe_rise) cap_m = w_in;
        end
        #32;
    endtask

    // Deserializer: frame found when the clock-lane history equals 1100011
    always @(negedge clk_bit) begin
        h_clk = {h_clk[SL-2:0], tx_clk};
        for (int l = 0; l < NL; l++) h_dat[l] = {h_dat[l][SL-2:0], tx_dat[l]};
        for (int i = SL - 1; i > 0; i--) h_exp[i] = h_exp[i-1];
        h_exp[0] = exp_stage;
        if (h_clk === 7'b1100011) begin
            frames++;
            if (chk_en) begin
                rec = {h_dat[2], h_dat[1], h_dat[0]};
                chk(rec === h_exp[SL-1], "R1 R2 R4 recovered word",
                    32'(rec), 32'(h_exp[SL-1]));
            end
        end
    end

    initial begin
        int f0;
        for (int l = 0; l < NL; l++) h_dat[l] = '0;
        for (int i = 0; i < SL; i++) h_exp[i] = '0;
        #2;
        repeat (3) pix_period(1, '0);
        chk(tx_dat === 3'bzzz, "R5 data lanes hi-z in power-down", 32'(tx_dat), 32'h0);
        chk(tx_clk === 1'bz, "R5 clock lane hi-z in power-down", 32'(tx_clk), 32'h0);
        chk(bitclk_en === 1'b0, "R5 bit clock enable low", 32'(bitclk_en), 32'h0);

        // release with no pixel clock
        pd_req = 1'b1;
        repeat (4) pix_period(0, '0);
        chk(tx_dat === 3'b000, "R6 data lanes low without clock", 32'(tx_dat), 32'h0);
        chk(tx_clk === 1'b0, "R6 clock lane low without clock", 32'(tx_clk), 32'h0);
        chk(bitclk_en === 1'b1, "R6 bit clock enable high", 32'(bitclk_en), 32'h1);

        // rising-edge sweep
        chk_en = 1;
        frames = 0;
        for (int i = 0; i < NP; i++) pix_period(1, pat(i));
        repeat (2) pix_period(1, pat(NP - 1));
        chk(frames >= NP - 4 && frames <= NP + 2, "R4 one frame per period rising",
            32'(frames), 32'(NP + 1));
        chk($countones(h_clk) == 4, "R3 clock lane four high slots",
            32'($countones(h_clk)), 32'h4);

        // stopped clock
        repeat (2) pix_period(0, pat(5));
        chk((|h_clk) === 1'b1, "R7 loss not declared early", 32'(h_clk), 32'h63);
        repeat (4) pix_period(0, pat(6));
        chk(h_clk === '0 && tx_clk === 1'b0, "R7 clock lane low after loss",
            32'(h_clk), 32'h0);
        chk(tx_dat === 3'b000, "R7 data lanes low after loss", 32'(tx_dat), 32'h0);
        chk(bitclk_en === 1'b1, "R7 bit clock enable stays high", 32'(bitclk_en), 32'h1);
        repeat (4) pix_period(0, pat(7));

        // restart without power-down
        f0 = frames;
        for (int i = 0; i < 12; i++) pix_period(1, pat(50 + i));
        chk(frames - f0 >= 10, "R8 frames resume after restart", 32'(frames - f0), 32'd12);

        // power-down in mid-run, switch to falling edge
        pd_req = 1'b0;
        str_req = 1'b0;
        repeat (3) pix_period(1, pat(9));
        chk(tx_dat === 3'bzzz && tx_clk === 1'bz, "R5 lanes hi-z after mid-run power-down",
            32'({tx_clk, tx_dat}), 32'h0);
        chk(bitclk_en === 1'b0, "R5 bit clock enable low again", 32'(bitclk_en), 32'h0);
        pd_req = 1'b1;
        frames = 0;
        for (int i = 0; i < NP; i++) pix_period(1, pat(NP - 1 - i));
        repeat (2) pix_period(1, pat(0));
        chk(frames >= NP - 4 && frames <= NP + 2, "R1 R4 frames falling edge",
            32'(frames), 32'(NP + 1));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #160000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule